// File: doc/BRIEF.md
# Keyed Restart Watchdog Timer

This block is a bus-mapped watchdog. Software writes a 4-bit interval code and an enable bit. It also selects what happens when the interval runs out: a latched system reset request, a pending interrupt, or nothing. Counting advances on a half-second tick-enable input. The interval codes follow a fixed nonlinear table, from half a second up to sixteen seconds.

To keep the system alive, software must write one exact restart word to the control register before the count runs out. Any other value written there is ignored. Setting the enable bit reloads the counter. Changing the interval while the timer runs also reloads it. Software updates the settings with read-modify-write, so every stored field reads back unchanged.

Top module: `wdt_key_timer`

## Requirements
- R1: Register offsets are 0x10 (restart control, reads 0), 0x14 (action, bits 1:0) and 0x18 (mode: enable bit 0, interval code bits 7:4). Stored fields read back exactly as written, all other bits read 0, and writes to other offsets change nothing.
- R2: Only a control write of exactly 0x000014AF (bit 0 set, 0xA57 in bits 12:1) reloads the counter. Any other value written to the control register neither reloads the counter nor clears a pending interrupt.
- R3: Interval code 0 gives 1 tick. Codes 1 to 6 give 2, 4, 6, 8, 10 and 12 ticks. Codes 7 to 0xB give 16, 20, 24, 28 and 32 ticks. The tick input pulses every half second.
- R4: Interval codes 0xC to 0xF behave like code 0xB (32 ticks).
- R5: While the enable bit is 0 the count is frozen and no expiry occurs. Writing 0 to the mode register stops the timer.
- R6: A mode write that sets the enable bit while the timer is off reloads the counter. So does a mode write that changes the code while the timer is on. Rewriting the same code while running does not reload.
- R7: Expiry happens on the Nth tick after a reload, where N is the decoded count. The counter then reloads itself and keeps counting.
- R8: With action 01, expiry raises sys_rst_req. It stays high, through restart writes and stop writes, until rst_n is asserted.
- R9: With action 10, expiry sets irq. irq stays high until a valid restart write clears it.
- R10: Actions 00 and 11 drive no output on expiry.
- R11: After reset all fields are 0, the timer is off, and sys_rst_req and irq are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Half-second count enable pulse |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr (combinational) |
| sys_rst_req | output | 1 | Latched system reset request |
| irq | output | 1 | Pending expiry interrupt |

## Verification
Several properties are checked on every cycle:
- the reset request stays high once raised;
- an interrupt or reset request appears only after a tick seen while enabled;
- a valid restart write leaves irq low;
- a disabled timer with no write keeps its count;
- a running counter is never zero or above 32.

Some behaviour can only be shown by the bench scenarios. These cover the exact tick count of every interval code, the effect of near-miss restart words, and reload on code change versus same-code rewrite. They also cover field readback and the self-reload after a silent expiry.

// File: rtl/wdt_key_timer.sv
module wdt_key_timer #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CNT_W = 6,
  parameter logic [ADDR_W-1:0] OFF_CTRL = 8'h10,
  parameter logic [ADDR_W-1:0] OFF_CFG  = 8'h14,
  parameter logic [ADDR_W-1:0] OFF_MODE = 8'h18,
  parameter logic [DATA_W-1:0] KEY = 32'h0000_14AF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              sys_rst_req,
  output logic              irq
);
  localparam logic [1:0] ACT_RST = 2'b01;
  localparam logic [1:0] ACT_IRQ = 2'b10;

  function automatic logic [CNT_W-1:0] ticks_for(input logic [3:0] c);
    int n;
    if (c == 4'd0)       n = 1;
    else if (c <= 4'd6)  n = 2 * int'(c);
    else if (c <= 4'd11) n = 4 * int'(c) - 12;
    else                 n = 32;
    return CNT_W'(n);
  endfunction

  logic [1:0]       act;
  logic             en;
  logic [3:0]       code;
  logic [CNT_W-1:0] cnt;
  logic             irq_q, rst_q;

  wire wr_cfg  = wr_en && addr == OFF_CFG;
  wire wr_mode = wr_en && addr == OFF_MODE;
  wire key_ok  = wr_en && addr == OFF_CTRL && wdata == KEY;
  wire [3:0] new_code = wdata[7:4];
  wire mode_reload = wr_mode && wdata[0] && (!en || new_code != code);
  wire reload  = key_ok || mode_reload;
  wire step    = tick && en && !wr_mode && !key_ok;
  wire expire  = step && cnt == CNT_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act <= '0;
      en <= 1'b0;
      code <= '0;
      cnt <= '0;
      irq_q <= 1'b0;
      rst_q <= 1'b0;
    end else begin
      if (wr_cfg) act <= wdata[1:0];
      if (wr_mode) begin
        en <= wdata[0];
        code <= new_code;
      end
      if (reload) cnt <= ticks_for(wr_mode ? new_code : code);
      else if (step) cnt <= expire ? ticks_for(code) : cnt - CNT_W'(1);
      if (expire && act == ACT_IRQ) irq_q <= 1'b1;
      else if (key_ok) irq_q <= 1'b0;
      if (expire && act == ACT_RST) rst_q <= 1'b1;
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == OFF_CFG) rdata[1:0] = act;
    else if (addr == OFF_MODE) begin
      rdata[0] = en;
      rdata[7:4] = code;
    end
  end

  assign irq = irq_q;
  assign sys_rst_req = rst_q;
endmodule

module wdt_key_timer_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CNT_W = 6,
  parameter logic [ADDR_W-1:0] OFF_CTRL = 8'h10,
  parameter logic [DATA_W-1:0] KEY = 32'h0000_14AF
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic              en,
  input logic [CNT_W-1:0]  cnt,
  input logic              irq,
  input logic              sys_rst_req
);
  p_rst_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_req |=> sys_rst_req);
  p_rst_after_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst_req) |-> $past(tick && en));
  p_irq_after_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(tick && en));
  p_key_clears_irq_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OFF_CTRL && wdata == KEY) |=> !irq);
  p_frozen_when_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !wr_en) |=> $stable(cnt));
  p_cnt_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> (cnt != '0 && cnt <= CNT_W'(32)));
endmodule

bind wdt_key_timer wdt_key_timer_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .OFF_CTRL(OFF_CTRL), .KEY(KEY)
) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .en(en), .cnt(cnt), .irq(irq), .sys_rst_req(sys_rst_req)
);

// File: tb/tb_wdt_key_timer.sv
module tb_wdt_key_timer;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, wr_en = 1'b0;
  logic [7:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic sys_rst_req, irq;
  int total = 0, bad = 0;
  bit done = 0;

  localparam logic [31:0] KEY = 32'h0000_14AF;

  always #10 clk = ~clk;

  wdt_key_timer dut (.clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .sys_rst_req(sys_rst_req), .irq(irq));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0; addr = '0; wdata = '0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1 d = rdata; addr = '0;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1;
      @(negedge clk); tick = 0;
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    @(negedge clk); @(negedge clk); rst_n = 1;
  endtask

  function automatic int exp_ticks(int c);
    if (c == 0) return 1;
    if (c <= 6) return 2 * c;
    if (c <= 11) return 4 * c - 12;
    return 32;
  endfunction

  task automatic t_reset_state();
    logic [31:0] d;
    do_reset();
    check("R11 rst_req", {31'b0, sys_rst_req}, 0);
    check("R11 irq", {31'b0, irq}, 0);
    rd(8'h18, d); check("R11 mode", d, 0);
    rd(8'h14, d); check("R11 cfg", d, 0);
  endtask

  task automatic t_readback();
    logic [31:0] d;
    wr(8'h14, 32'hFFFF_FFFE); rd(8'h14, d); check("R1 cfg field", d, 32'h2);
    wr(8'h18, 32'hFFFF_FF70); rd(8'h18, d); check("R1 mode field", d, 32'h70);
    wr(8'h1C, 32'hFFFF_FFFF); rd(8'h18, d); check("R1 unmapped write", d, 32'h70);
    rd(8'h14, d); check("R1 cfg kept", d, 32'h2);
    rd(8'h10, d); check("R1 ctrl reads 0", d, 0);
    wr(8'h18, 0);
  endtask

  task automatic t_interval(int c, string req);
    int n = exp_ticks(c);
    wr(8'h18, 0); wr(8'h10, KEY); wr(8'h14, 32'h2);
    wr(8'h18, (c << 4) | 1);
    ticks(n - 1);
    check({req, " before expiry"}, {31'b0, irq}, 0);
    ticks(1);
    check({req, " at expiry"}, {31'b0, irq}, 1);
    wr(8'h18, 0); wr(8'h10, KEY);
  endtask

  task automatic t_key();
    wr(8'h14, 32'h2); wr(8'h18, 32'h11);
    ticks(1); wr(8'h10, 32'h0000_14AE); ticks(1);
    check("R2 bit0 clear ignored", {31'b0, irq}, 1);
    wr(8'h10, KEY | 32'h2000);
    check("R2 extra bit no clear", {31'b0, irq}, 1);
    wr(8'h10, 32'h0000_14B1);
    check("R2 wrong key no clear", {31'b0, irq}, 1);
    wr(8'h10, KEY);
    check("R9 key clears irq", {31'b0, irq}, 0);
    ticks(1); wr(8'h10, KEY); ticks(1);
    check("R2 key reloads", {31'b0, irq}, 0);
    ticks(1);
    check("R2 expiry after reload", {31'b0, irq}, 1);
    wr(8'h18, 0); wr(8'h10, KEY);
  endtask

  task automatic t_disable();
    logic [31:0] d;
    wr(8'h14, 32'h2); wr(8'h18, 32'h11);
    ticks(1); wr(8'h18, 32'h10); ticks(5);
    check("R5 frozen when off", {31'b0, irq}, 0);
    rd(8'h18, d); check("R5 mode off readback", d, 32'h10);
    wr(8'h18, 32'h11); ticks(1);
    check("R6 enable reloads", {31'b0, irq}, 0);
    ticks(1);
    check("R6 expiry after enable", {31'b0, irq}, 1);
    wr(8'h18, 0); wr(8'h10, KEY);
  endtask

  task automatic t_code_change();
    wr(8'h14, 32'h2); wr(8'h18, 32'h21);
    ticks(3); wr(8'h18, 32'h11); ticks(1);
    check("R6 code change reloads", {31'b0, irq}, 0);
    ticks(1);
    check("R6 new code expiry", {31'b0, irq}, 1);
    wr(8'h18, 0); wr(8'h10, KEY);
    wr(8'h18, 32'h21); ticks(3); wr(8'h18, 32'h21); ticks(1);
    check("R6 same code no reload", {31'b0, irq}, 1);
    wr(8'h18, 0); wr(8'h10, KEY);
  endtask

  task automatic t_silent_and_continue();
    wr(8'h14, 32'h0); wr(8'h18, 32'h11); ticks(2);
    check("R10 action 00 irq", {31'b0, irq}, 0);
    check("R10 action 00 rst", {31'b0, sys_rst_req}, 0);
    wr(8'h14, 32'h2); ticks(1);
    check("R7 self reload mid", {31'b0, irq}, 0);
    ticks(1);
    check("R7 second expiry", {31'b0, irq}, 1);
    wr(8'h18, 0); wr(8'h10, KEY);
    wr(8'h14, 32'h3); wr(8'h18, 32'h01); ticks(3);
    check("R10 action 11 irq", {31'b0, irq}, 0);
    check("R10 action 11 rst", {31'b0, sys_rst_req}, 0);
    wr(8'h18, 0);
  endtask

  task automatic t_sys_reset();
    wr(8'h14, 32'h1); wr(8'h18, 32'h01);
    check("R8 before tick", {31'b0, sys_rst_req}, 0);
    ticks(1);
    check("R8 rst on expiry", {31'b0, sys_rst_req}, 1);
    check("R8 no irq", {31'b0, irq}, 0);
    wr(8'h10, KEY); wr(8'h18, 0);
    check("R8 rst sticky", {31'b0, sys_rst_req}, 1);
    do_reset();
    check("R8 cleared by rst_n", {31'b0, sys_rst_req}, 0);
  endtask

  initial begin
    t_reset_state();
    t_readback();
    for (int c = 0; c < 12; c++) t_interval(c, "R3");
    for (int c = 12; c < 16; c++) t_interval(c, "R4");
    t_key();
    t_disable();
    t_code_change();
    t_silent_and_continue();
    t_sys_reset();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule